// File: doc/BRIEF.md
# Prescaled Reloading Down-Counter Timer

This block is an interval timer that measures time in base-clock ticks. Each cycle the surrounding core reports how many base-clock ticks the step it just completed took. The timer adds that amount to a prescaler accumulator, four times the amount when the core runs in its slow mode. Every full 1024 ticks gathered in the accumulator takes one count off an 8-bit down-counter, and the remainder stays in the accumulator.

When a decrement would take the counter below zero, the counter takes the stored reload value instead and an interrupt request is raised. The request stays up until it is acknowledged. One large step can hold several 1024-tick multiples. These are applied one after another in the same cycle, so a reload partway through the step is followed by further decrements of the reloaded value. Software controls the timer with an enable level and a reload write port, and reads the running count.

Top module: `tmr_interval_timer`

## Requirements
- R1: Reset makes count 0 and irq 0, clears the prescaler, the stored reload value and the stored enable state. A rising enable seen after reset loads 0.
- R2: In the first cycle that enable is high after being low (or after reset), the counter loads the stored reload value as it was before any write in that same cycle, the prescaler is cleared, and that cycle's step is not counted.
- R3: While enable is low, step inputs have no effect: count and prescaler hold.
- R4: While running, each step with step_valid high adds step_ticks to the prescaler. Each full 1024 accumulated takes one off count, and the remainder carries to later steps.
- R5: With low_speed high, a step contributes step_ticks multiplied by 4.
- R6: A decrement applied to a count of 0 loads the reload value instead of 0xFF and sets irq on the next clock edge.
- R7: One step that carries k full multiples of 1024 applies k decrements in order within that cycle, reloading at every pass through zero.
- R8: irq stays high until irq_ack is high in a cycle with no underflow, after which it is 0.
- R9: irq_ack in the same cycle as an underflow leaves irq at 1.
- R10: A reload write never changes count. The new value is used at the next underflow or enable rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Timer run level |
| step_valid | input | 1 | A step of step_ticks base cycles completed this cycle |
| step_ticks | input | STEP_W (12) | Base-clock cycles of the completed step |
| low_speed | input | 1 | Slow mode: step counts four times |
| reload_we | input | 1 | Write strobe for the reload value |
| reload_data | input | CNT_W (8) | Reload value to store |
| irq_ack | input | 1 | Clears the request |
| count | output | CNT_W (8) | Running counter value |
| irq | output | 1 | Timer interrupt request |

## Verification
A wrong prescaler remainder stays hidden until the next 1024-tick boundary. It then shows as a decrement one step early or one step late, so the table feeds sums that land just below and exactly on the boundary. A reload applied at the wrong point of a multi-decrement step gives a count off by the remaining decrements in the very next cycle. A mishandled acknowledge race shows on irq one edge after the step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // slow mode scales each step by 1 << TMR_SLOW_SHIFT
  localparam int unsigned TMR_SLOW_SHIFT = 2;
  localparam int unsigned TMR_SLOW_MULT  = 1 << TMR_SLOW_SHIFT;

  typedef enum logic [1:0] {
    TMR_IDLE  = 2'd0,
    TMR_START = 2'd1,
    TMR_RUN   = 2'd2
  } tmr_phase_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRESCALE = 1024,
  parameter int unsigned STEP_W   = 12,
  parameter int unsigned DEC_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [STEP_W-1:0] step_ticks,
  input  logic              low_speed,
  output logic [DEC_W-1:0]  dec_cnt
);
  localparam int unsigned PRE_W = $clog2(PRESCALE);
  localparam int unsigned SUM_W = PRE_W + STEP_W + tmr_pkg::TMR_SLOW_SHIFT + 1;

  logic [PRE_W-1:0] acc_q;
  logic [SUM_W-1:0] scaled;
  logic [SUM_W-1:0] total;

  function automatic logic [SUM_W-1:0] scale_step(input logic [STEP_W-1:0] t,
                                                   input logic slow);
    logic [SUM_W-1:0] w;
    w = SUM_W'(t);
    return slow ? (w << tmr_pkg::TMR_SLOW_SHIFT) : w;
  endfunction

  always_comb begin
    scaled  = scale_step(step_ticks, low_speed);
    total   = SUM_W'(acc_q) + scaled;
    dec_cnt = adv ? DEC_W'(total >> PRE_W) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc_q <= '0;
    else if (adv)      acc_q <= total[PRE_W-1:0];
  end
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned DEC_W   = 5,
  parameter int unsigned MAX_DEC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             reload_we,
  input  logic [CNT_W-1:0] reload_data,
  input  logic [DEC_W-1:0] dec_cnt,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload_q,
  output logic             underflow
);
  logic [CNT_W:0]   walk_res;
  logic [CNT_W-1:0] count_nxt;

  // apply n decrements one at a time; a pass through zero reloads
  function automatic logic [CNT_W:0] walk(input logic [CNT_W-1:0] start,
                                          input logic [CNT_W-1:0] rel,
                                          input logic [DEC_W-1:0] n);
    logic [CNT_W-1:0] cur;
    logic             uf;
    cur = start;
    uf  = 1'b0;
    for (int i = 0; i < MAX_DEC; i++) begin
      if (DEC_W'(i) < n) begin
        if (cur == '0) begin
          cur = rel;
          uf  = 1'b1;
        end else begin
          cur = cur - 1'b1;
        end
      end
    end
    return {uf, cur};
  endfunction

  always_comb begin
    walk_res  = walk(count, reload_q, dec_cnt);
    count_nxt = walk_res[CNT_W-1:0];
    underflow = walk_res[CNT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      count    <= '0;
    end else begin
      if (reload_we) reload_q <= reload_data;
      if (load)      count    <= reload_q;
      else           count    <= count_nxt;
    end
  end
endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)   irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (ack) irq <= 1'b0;
  end
endmodule

// File: rtl/tmr_interval_timer.sv
module tmr_interval_timer #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned STEP_W   = 12,
  parameter int unsigned PRESCALE = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              step_valid,
  input  logic [STEP_W-1:0] step_ticks,
  input  logic              low_speed,
  input  logic              reload_we,
  input  logic [CNT_W-1:0]  reload_data,
  input  logic              irq_ack,
  output logic [CNT_W-1:0]  count,
  output logic              irq
);
  localparam int unsigned MAX_DEC =
    (((1 << STEP_W) - 1) * tmr_pkg::TMR_SLOW_MULT + PRESCALE - 1) / PRESCALE;
  localparam int unsigned DEC_W = $clog2(MAX_DEC + 1);

  tmr_pkg::tmr_phase_e phase;
  logic             enable_q;
  logic             en_rise;
  logic             adv;
  logic [DEC_W-1:0] dec_cnt;
  logic [CNT_W-1:0] reload_q;
  logic             underflow;

  always_ff @(posedge clk) begin
    if (!rst_n) enable_q <= 1'b0;
    else        enable_q <= enable;
  end

  always_comb begin
    en_rise = enable & ~enable_q;
    adv     = enable & enable_q & step_valid;
    if (en_rise)     phase = tmr_pkg::TMR_START;
    else if (enable) phase = tmr_pkg::TMR_RUN;
    else             phase = tmr_pkg::TMR_IDLE;
  end

  tmr_prescaler #(.PRESCALE(PRESCALE), .STEP_W(STEP_W), .DEC_W(DEC_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (phase == tmr_pkg::TMR_START),
    .adv       (adv),
    .step_ticks(step_ticks),
    .low_speed (low_speed),
    .dec_cnt   (dec_cnt)
  );

  tmr_downcount #(.CNT_W(CNT_W), .DEC_W(DEC_W), .MAX_DEC(MAX_DEC)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (en_rise),
    .reload_we  (reload_we),
    .reload_data(reload_data),
    .dec_cnt    (dec_cnt),
    .count      (count),
    .reload_q   (reload_q),
    .underflow  (underflow)
  );

  tmr_irq_flag u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (underflow),
    .ack  (irq_ack),
    .irq  (irq)
  );
endmodule

// File: rtl/tmr_interval_timer_chk.sv
module tmr_interval_timer_chk #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned DEC_W   = 5,
  parameter int unsigned MAX_DEC = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             en_rise,
  input logic             reload_we,
  input logic             irq_ack,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload_q,
  input logic             underflow,
  input logic [DEC_W-1:0] dec_cnt
);
  AST_RISE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> count == $past(reload_q)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(count)); // R3
  AST_UF_NEEDS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> dec_cnt != '0); // R6
  AST_UF_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> irq); // R6
  AST_DEC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    dec_cnt <= DEC_W'(MAX_DEC)); // R7
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_ack |=> irq); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !underflow |=> !irq); // R8
  AST_ACK_RACE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && underflow |=> irq); // R9
  AST_RELOAD_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
    reload_we && !en_rise && dec_cnt == '0 |=> $stable(count)); // R10
endmodule

bind tmr_interval_timer tmr_interval_timer_chk #(
  .CNT_W(CNT_W), .DEC_W(DEC_W), .MAX_DEC(MAX_DEC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .en_rise  (en_rise),
  .reload_we(reload_we),
  .irq_ack  (irq_ack),
  .irq      (irq),
  .count    (count),
  .reload_q (reload_q),
  .underflow(underflow),
  .dec_cnt  (dec_cnt)
);

// File: tb/tmr_interval_timer_test.sv
module tmr_interval_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, step_valid, low_speed, reload_we, irq_ack;
  logic [11:0] step_ticks;
  logic [7:0]  reload_data;
  logic [7:0]  count;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_interval_timer uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .step_valid(step_valid),
    .step_ticks(step_ticks), .low_speed(low_speed), .reload_we(reload_we),
    .reload_data(reload_data), .irq_ack(irq_ack), .count(count), .irq(irq)
  );

  typedef struct packed {
    logic        en;
    logic        sv;
    logic [11:0] el;
    logic        ls;
    logic        we;
    logic [7:0]  wd;
    logic        ack;
    logic [7:0]  ecnt;
    logic        eirq;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 12'd0,    1'b0, 1'b1, 8'h03, 1'b0, 8'h00, 1'b0}, // R10 write while idle
    '{1'b1, 1'b1, 12'd1000, 1'b0, 1'b0, 8'h00, 1'b0, 8'h03, 1'b0}, // R2 rise loads, step dropped
    '{1'b1, 1'b1, 12'd1000, 1'b0, 1'b0, 8'h00, 1'b0, 8'h03, 1'b0}, // R4 acc 1000
    '{1'b1, 1'b1, 12'd24,   1'b0, 1'b0, 8'h00, 1'b0, 8'h02, 1'b0}, // R4 exactly 1024
    '{1'b1, 1'b1, 12'd1023, 1'b0, 1'b0, 8'h00, 1'b0, 8'h02, 1'b0}, // R4 just below
    '{1'b1, 1'b1, 12'd1,    1'b0, 1'b0, 8'h00, 1'b0, 8'h01, 1'b0}, // R4 remainder carried
    '{1'b1, 1'b1, 12'd256,  1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0}, // R5 256 x4
    '{1'b1, 1'b1, 12'd1024, 1'b0, 1'b0, 8'h00, 1'b0, 8'h03, 1'b1}, // R6 wrap reloads
    '{1'b1, 1'b0, 12'd0,    1'b0, 1'b0, 8'h00, 1'b0, 8'h03, 1'b1}, // R8 holds
    '{1'b1, 1'b0, 12'd0,    1'b0, 1'b0, 8'h00, 1'b1, 8'h03, 1'b0}, // R8 ack clears
    '{1'b1, 1'b0, 12'd0,    1'b0, 1'b1, 8'h10, 1'b0, 8'h03, 1'b0}, // R10 count untouched
    '{1'b1, 1'b1, 12'd1024, 1'b1, 1'b0, 8'h00, 1'b0, 8'h10, 1'b1}, // R7 4 decs via zero
    '{1'b1, 1'b0, 12'd0,    1'b0, 1'b0, 8'h00, 1'b1, 8'h10, 1'b0}, // R8 ack
    '{1'b1, 1'b1, 12'd4095, 1'b1, 1'b0, 8'h00, 1'b0, 8'h01, 1'b0}, // R7 15 decs, rem 1020
    '{1'b1, 1'b1, 12'd4,    1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0}, // R4 1020+4
    '{1'b1, 1'b1, 12'd1024, 1'b0, 1'b0, 8'h00, 1'b1, 8'h10, 1'b1}, // R9 ack with underflow
    '{1'b1, 1'b1, 12'd512,  1'b0, 1'b0, 8'h00, 1'b0, 8'h10, 1'b1}, // R4 acc 512
    '{1'b0, 1'b1, 12'd4095, 1'b1, 1'b0, 8'h00, 1'b0, 8'h10, 1'b1}, // R3 idle ignores step
    '{1'b0, 1'b0, 12'd0,    1'b0, 1'b1, 8'h22, 1'b0, 8'h10, 1'b1}, // R10 write while idle
    '{1'b1, 1'b1, 12'd4095, 1'b1, 1'b1, 8'h55, 1'b0, 8'h22, 1'b1}, // R2 old value loads
    '{1'b1, 1'b1, 12'd1023, 1'b0, 1'b0, 8'h00, 1'b0, 8'h22, 1'b1}, // R2 prescaler cleared
    '{1'b1, 1'b1, 12'd1,    1'b0, 1'b0, 8'h00, 1'b0, 8'h21, 1'b1}, // R4
    '{1'b1, 1'b1, 12'd1024, 1'b0, 1'b0, 8'h00, 1'b1, 8'h20, 1'b0}  // R8 ack, no underflow
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    enable = v.en; step_valid = v.sv; step_ticks = v.el; low_speed = v.ls;
    reload_we = v.we; reload_data = v.wd; irq_ack = v.ack;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive('0);
    repeat (3) @(negedge clk);
    check("R1 reset count", count, 8'h00);
    check("R1 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      check($sformatf("row %0d count", i), count, TBL[i].ecnt);
      check($sformatf("row %0d irq", i), {7'd0, irq}, {7'd0, TBL[i].eirq});
    end

    // R1: reset in the middle of a run, enable held high across it
    drive('0);
    enable = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 midrun count", count, 8'h00);
    check("R1 midrun irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rise loads cleared reload", count, 8'h00);
    // R6: reload value 0 wraps to 0 and raises the request
    step_valid = 1'b1; step_ticks = 12'd1024;
    @(negedge clk);
    check("R6 zero reload count", count, 8'h00);
    check("R6 zero reload irq", {7'd0, irq}, 8'h01);
    step_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule